// File: doc/BRIEF.md
# Three-Phase Voltage Sag Detector

This block watches a stream of signed voltage samples from three line phases and decides, phase by phase, when the supply has sagged. A phase is in sag once the magnitude of its voltage has stayed below a programmable level for a programmable number of consecutive valid samples. The sag flag then latches. It drops again as soon as a single sample from that phase rises above the level. Each phase can be switched off with its own enable bit. While a phase is off, its run counter and flag are held at zero.

The block also derives a square wave at the line frequency from the sign of the phase A samples. A small hysteresis band around zero keeps the wave from chattering near zero crossings. Once per processing pass, a pass-complete strobe copies the three flags and the square wave into a 32-bit status word, which holds still until the next strobe. When the sag interrupt enable is set, every new sag event toggles a pulse line, so a downstream edge detector sees each event.

Each phase is a three-state machine. `PH_OFF` is held while the phase enable is low. `PH_ARMED` counts consecutive low samples. `PH_SAGGED` holds the latched flag. The transitions between them are:

| Transition | Condition |
|---|---|
| enable / disable | `PH_OFF`→`PH_ARMED` when the enable goes high; any state→`PH_OFF` when the enable is low |
| run reached | `PH_ARMED`→`PH_SAGGED` when the low run reaches the programmed count |
| recover | `PH_SAGGED`→`PH_ARMED` on a sample above the level |

The square wave is a two-state machine. It moves `F0_NEG`→`F0_POS` when a phase A sample exceeds +HYST. It moves `F0_POS`→`F0_NEG` when a sample falls below −HYST.

Top module: `vsag_monitor`

## Requirements
- R1: A sample's magnitude is its absolute value as a 16-bit two's complement number, and −32768 saturates to 32767. A sample counts as low only when its magnitude is strictly less than `sag_level`.
- R2: A phase's flag sets on the valid sample that completes a run of `sag_runlen` consecutive low valid samples. A `sag_runlen` of 0 behaves as 1. Cycles without `smp_vld` neither advance nor break the run, and they leave the flags unchanged.
- R3: A valid sample whose magnitude is greater than `sag_level` clears that phase's flag and run. A sample whose magnitude equals `sag_level` clears the run but leaves a set flag set.
- R4: `phase_en` bit 0 enables phase A, bit 1 phase B and bit 2 phase C. While a bit is 0, that phase's run and flag are zero and no sample can set the flag.
- R5: On each cycle with `pass_done`, `status_word` loads bit 28 = square wave, bit 27 = C flag, bit 26 = B flag and bit 25 = A flag, using the values held before that clock edge. Bits 31:29 and 24:0 are always zero, and the word holds its value between strobes.
- R6: The square wave goes to 1 on a valid phase A sample greater than +HYST (64 by default) and to 0 on one less than −HYST. Samples inside the band, including ±64, keep its value.
- R7: While `sag_irq_en` is 1, `sag_pulse` toggles one clock after a sample sets at least one flag. It toggles once even when several phases set on the same sample, and it never toggles while `sag_irq_en` is 0.
- R8: After reset, the flags, runs, square wave, `sag_pulse` and `status_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | The three samples are valid this cycle |
| smp_a | input | 16 | Phase A sample, signed |
| smp_b | input | 16 | Phase B sample, signed |
| smp_c | input | 16 | Phase C sample, signed |
| sag_level | input | 16 | Magnitude threshold, unsigned |
| sag_runlen | input | 8 | Consecutive low samples needed to flag |
| phase_en | input | 3 | Per-phase detection enable (bit 0 = A) |
| sag_irq_en | input | 1 | Allow sag events to toggle `sag_pulse` |
| pass_done | input | 1 | Pass-complete strobe, captures the status word |
| status_word | output | 32 | Packed flags and square wave from the last pass |
| sag_pulse | output | 1 | Toggles on each sag event |

## Verification
The assertions check every cycle that the reserved status bits stay zero and that the word moves only on a strobe. They also check that flags and the square wave hold when no sample is valid, and that a disabled phase has no flag one cycle later. A sample above the level must clear phase A's flag, and the pulse line may change only after a valid sample with the interrupt enable high. What the assertions cannot show, the bench's scenarios must. These are the exact sample on which a run completes, the equal-to-level and −32768 corner cases, and the once-only toggle for simultaneous events. They also include the old-value capture when a strobe meets a setting sample, and the hysteresis edges at ±64. A behavioural model checks all of these cycle by cycle.

// File: rtl/vsag_pkg.sv
package vsag_pkg;

    localparam int NPH       = 3;
    localparam int STAT_W    = 32;
    localparam int F0_BIT    = 28;
    localparam int SAG_A_BIT = 25;

    typedef enum logic [1:0] {
        PH_OFF     = 2'd0,
        PH_ARMED   = 2'd1,
        PH_SAGGED  = 2'd2
    } ph_state_t;

    typedef enum logic {
        F0_NEG = 1'b0,
        F0_POS = 1'b1
    } f0_state_t;

    function automatic logic [STAT_W-1:0] pack_status(input logic f0,
                                                      input logic [NPH-1:0] flags);
        logic [STAT_W-1:0] w;
        w = '0;
        w[F0_BIT]             = f0;
        w[SAG_A_BIT +: NPH]   = flags;
        return w;
    endfunction

endpackage

// File: rtl/vsag_mag.sv
module vsag_mag #(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] smp,
    output logic        [DW-1:0] mag
);
    localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};

    always_comb begin
        if (!smp[DW-1]) begin
            mag = smp;
        end else if (smp == MIN_NEG) begin
            mag = MAX_POS;
        end else begin
            mag = DW'(0) - smp;
        end
    end
endmodule

// File: rtl/vsag_phase.sv
module vsag_phase
    import vsag_pkg::*;
#(
    parameter int DW    = 16,
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             vld,
    input  logic [DW-1:0]    mag,
    input  logic [DW-1:0]    level,
    input  logic [RUN_W-1:0] runlen,
    output logic             flag,
    output logic             sag_evt
);
    ph_state_t        st_q, st_d;
    logic [RUN_W-1:0] cnt_q, cnt_d;
    logic             below, above, reach;
    logic [RUN_W:0]   run_nxt;

    assign below   = (mag < level);
    assign above   = (mag > level);
    assign run_nxt = {1'b0, cnt_q} + {{RUN_W{1'b0}}, 1'b1};
    assign reach   = (run_nxt >= {1'b0, runlen});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PH_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!en) begin
            st_d  = PH_OFF;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                PH_OFF, PH_ARMED: begin
                    st_d = PH_ARMED;
                    if (vld) begin
                        if (below) begin
                            if (reach) begin
                                st_d  = PH_SAGGED;
                                cnt_d = runlen;
                            end else begin
                                cnt_d = run_nxt[RUN_W-1:0];
                            end
                        end else begin
                            cnt_d = '0;
                        end
                    end
                end
                PH_SAGGED: begin
                    if (vld && !below) begin
                        cnt_d = '0;
                        if (above) begin
                            st_d = PH_ARMED;
                        end
                    end
                end
                default: begin
                    st_d  = PH_OFF;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        flag    = (st_q == PH_SAGGED);
        sag_evt = en && vld && below && reach && (st_q != PH_SAGGED);
    end
endmodule

// File: rtl/vsag_fund.sv
module vsag_fund
    import vsag_pkg::*;
#(
    parameter int DW   = 16,
    parameter int HYST = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld,
    input  logic signed [DW-1:0] smp,
    output logic                 f0
);
    localparam logic signed [DW-1:0] HI = DW'(HYST);
    localparam logic signed [DW-1:0] LO = -HI;

    f0_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= F0_NEG;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        if (vld) begin
            unique case (st_q)
                F0_NEG: if (smp > HI) st_d = F0_POS;
                F0_POS: if (smp < LO) st_d = F0_NEG;
                default: st_d = F0_NEG;
            endcase
        end
    end

    always_comb begin
        f0 = (st_q == F0_POS);
    end
endmodule

// File: rtl/vsag_monitor.sv
module vsag_monitor
    import vsag_pkg::*;
#(
    parameter int DW    = 16,
    parameter int RUN_W = 8,
    parameter int HYST  = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld,
    input  logic signed [DW-1:0] smp_a,
    input  logic signed [DW-1:0] smp_b,
    input  logic signed [DW-1:0] smp_c,
    input  logic        [DW-1:0] sag_level,
    input  logic     [RUN_W-1:0] sag_runlen,
    input  logic       [NPH-1:0] phase_en,
    input  logic                 sag_irq_en,
    input  logic                 pass_done,
    output logic    [STAT_W-1:0] status_word,
    output logic                 sag_pulse
);
    logic signed [DW-1:0] smp_arr [NPH];
    logic        [DW-1:0] mag_arr [NPH];
    logic       [NPH-1:0] flag_vec;
    logic       [NPH-1:0] evt_vec;
    logic                 f0_q;
    logic        [DW-1:0] mag_a;

    assign smp_arr[0] = smp_a;
    assign smp_arr[1] = smp_b;
    assign smp_arr[2] = smp_c;
    assign mag_a      = mag_arr[0];

    for (genvar g = 0; g < NPH; g++) begin : g_ph
        vsag_mag #(.DW(DW)) u_mag (
            .smp (smp_arr[g]),
            .mag (mag_arr[g])
        );
        vsag_phase #(.DW(DW), .RUN_W(RUN_W)) u_phase (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (phase_en[g]),
            .vld     (smp_vld),
            .mag     (mag_arr[g]),
            .level   (sag_level),
            .runlen  (sag_runlen),
            .flag    (flag_vec[g]),
            .sag_evt (evt_vec[g])
        );
    end

    vsag_fund #(.DW(DW), .HYST(HYST)) u_fund (
        .clk   (clk),
        .rst_n (rst_n),
        .vld   (smp_vld),
        .smp   (smp_a),
        .f0    (f0_q)
    );

    // status capture and event pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_word <= '0;
            sag_pulse   <= 1'b0;
        end else begin
            if (pass_done) begin
                status_word <= pack_status(f0_q, flag_vec);
            end
            if (sag_irq_en && (|evt_vec)) begin
                sag_pulse <= ~sag_pulse;
            end
        end
    end
endmodule

// File: rtl/vsag_monitor_chk.sv
module vsag_monitor_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_vld,
    input logic          pass_done,
    input logic          sag_irq_en,
    input logic [2:0]    phase_en,
    input logic [DW-1:0] sag_level,
    input logic [31:0]   status_word,
    input logic          sag_pulse,
    input logic [2:0]    flag_vec,
    input logic          f0_q,
    input logic [DW-1:0] mag_a
);
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[31:29] == 3'b000) && (status_word[24:0] == 25'd0)); // R5
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_done |=> $stable(status_word)); // R5
    AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && phase_en == 3'b111) |=> $stable(flag_vec)); // R2
    AST_ABOVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && phase_en[0] && mag_a > sag_level) |=> !flag_vec[0]); // R3
    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en != 3'b111) |=> ((flag_vec & ~$past(phase_en)) == 3'b000)); // R4
    AST_F0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(f0_q)); // R6
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (sag_pulse != $past(sag_pulse)) |-> $past(sag_irq_en && smp_vld)); // R7
    AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sag_irq_en |=> $stable(sag_pulse)); // R7
endmodule

bind vsag_monitor vsag_monitor_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_vld     (smp_vld),
    .pass_done   (pass_done),
    .sag_irq_en  (sag_irq_en),
    .phase_en    (phase_en),
    .sag_level   (sag_level),
    .status_word (status_word),
    .sag_pulse   (sag_pulse),
    .flag_vec    (flag_vec),
    .f0_q        (f0_q),
    .mag_a       (mag_a)
);

// File: tb/vsag_monitor_bench.sv
module vsag_monitor_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_vld = 1'b0;
    logic signed [15:0] smp_a = '0, smp_b = '0, smp_c = '0;
    logic [15:0]        sag_level = 16'd1000;
    logic [7:0]         sag_runlen = 8'd4;
    logic [2:0]         phase_en = 3'b111;
    logic               sag_irq_en = 1'b1;
    logic               pass_done = 1'b0;
    logic [31:0]        status_word;
    logic               sag_pulse;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vsag_monitor u_vsag_monitor (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .smp_a(smp_a), .smp_b(smp_b), .smp_c(smp_c),
        .sag_level(sag_level), .sag_runlen(sag_runlen),
        .phase_en(phase_en), .sag_irq_en(sag_irq_en),
        .pass_done(pass_done), .status_word(status_word),
        .sag_pulse(sag_pulse)
    );

    // ---------------- behavioural reference model ----------------
    bit [2:0]   m_flag;
    int         m_cnt [3];
    bit         m_f0;
    bit         m_pulse;
    bit [31:0]  m_status;

    function automatic int mag_of(input int v);
        int r;
        r = (v < 0) ? -v : v;
        if (r > 32767) r = 32767;
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flag = '0; m_f0 = 0; m_pulse = 0; m_status = '0;
            for (int p = 0; p < 3; p++) m_cnt[p] = 0;
        end else begin
            int s [3];
            bit ev;
            s[0] = $signed(smp_a); s[1] = $signed(smp_b); s[2] = $signed(smp_c);
            if (pass_done) begin
                m_status = 32'd0;
                m_status[28] = m_f0;
                m_status[27] = m_flag[2];
                m_status[26] = m_flag[1];
                m_status[25] = m_flag[0];
            end
            ev = 0;
            for (int p = 0; p < 3; p++) begin
                if (!phase_en[p]) begin
                    m_flag[p] = 0; m_cnt[p] = 0;
                end else if (smp_vld) begin
                    int mg;
                    mg = mag_of(s[p]);
                    if (mg < int'(sag_level)) begin
                        if (!m_flag[p]) begin
                            if (m_cnt[p] + 1 >= int'(sag_runlen)) begin
                                m_flag[p] = 1; m_cnt[p] = sag_runlen; ev = 1;
                            end else begin
                                m_cnt[p] = m_cnt[p] + 1;
                            end
                        end
                    end else begin
                        m_cnt[p] = 0;
                        if (mg > int'(sag_level)) m_flag[p] = 0;
                    end
                end
            end
            if (ev && sag_irq_en) m_pulse = !m_pulse;
            if (smp_vld) begin
                if (!m_f0 && s[0] > 64) m_f0 = 1;
                else if (m_f0 && s[0] < -64) m_f0 = 0;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (status_word !== m_status) begin
                failures++;
                $display("FAIL R5 cycle compare status act=%h exp=%h", status_word, m_status);
            end
            checks++;
            if (sag_pulse !== m_pulse) begin
                failures++;
                $display("FAIL R7 cycle compare pulse act=%0b exp=%0b", sag_pulse, m_pulse);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input int a, input int b, input int c, input bit pd);
        @(negedge clk);
        smp_vld = v; smp_a = 16'(a); smp_b = 16'(b); smp_c = 16'(c); pass_done = pd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
    endtask

    task automatic pass_chk(input string tag, input logic [31:0] exp);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0);
        chk(tag, status_word, exp);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        chk("R8 reset status", status_word, 32'h0);
        chk("R8 reset pulse", {31'd0, sag_pulse}, 32'd0);

        // R2: run of four
        for (int i = 0; i < 3; i++) cyc(1, -100, 5000, 5000, 0);
        pass_chk("R2 three lows no flag", 32'h0);
        cyc(1, -100, 5000, 5000, 0);
        pass_chk("R2 fourth low sets A", 32'h0200_0000);
        chk("R7 pulse after A event", {31'd0, sag_pulse}, 32'd1);

        // R3: equal keeps, above clears, equal resets run
        cyc(1, -1000, 5000, 5000, 0);
        pass_chk("R3 equal keeps flag", 32'h0200_0000);
        cyc(1, -1001, 5000, 5000, 0);
        pass_chk("R3 above clears flag", 32'h0);
        for (int i = 0; i < 3; i++) cyc(1, -100, 5000, 5000, 0);
        cyc(1, 1000, 5000, 5000, 0);
        cyc(1, -100, 5000, 5000, 0);
        pass_chk("R3 equal breaks run", 32'h0);
        for (int i = 0; i < 3; i++) cyc(1, -100, 5000, 5000, 0);
        pass_chk("R3 new run completes", 32'h0200_0000);
        cyc(1, -5000, 5000, 5000, 0);

        // R2: gaps without valid do not break the run
        for (int i = 0; i < 2; i++) cyc(1, -100, 5000, 5000, 0);
        idle(5);
        for (int i = 0; i < 2; i++) cyc(1, -100, 5000, 5000, 0);
        pass_chk("R2 run across gaps", 32'h0200_0000);
        cyc(1, -5000, 5000, 5000, 0);
        pass_chk("R3 clear after gaps", 32'h0);

        // R1: magnitude saturation and strict compare
        sag_level = 16'd32767; sag_runlen = 8'd1;
        cyc(1, -32768, -32768, -32768, 0);
        cyc(1, -32767, -32768, -32768, 0);
        pass_chk("R1 saturated and equal not low", 32'h0);
        cyc(1, -32766, -32768, -32768, 0);
        pass_chk("R1 just below sets A", 32'h0200_0000);
        sag_level = 16'd1000;
        cyc(1, -5000, 5000, 5000, 0);
        pass_chk("R1 cleared", 32'h0);

        // R4: per-phase enable
        sag_runlen = 8'd2;
        for (int i = 0; i < 2; i++) cyc(1, -5000, -100, 5000, 0);
        pass_chk("R4 B set while enabled", 32'h0400_0000);
        phase_en = 3'b101;
        idle(1);
        pass_chk("R4 disable clears B", 32'h0);
        for (int i = 0; i < 3; i++) cyc(1, -5000, -100, 5000, 0);
        pass_chk("R4 disabled B ignores lows", 32'h0);
        chk("R4 no pulse from disabled B", {31'd0, sag_pulse}, {31'd0, m_pulse});
        phase_en = 3'b111;
        cyc(1, -5000, 5000, 5000, 0);

        // R7: simultaneous events, one toggle; irq off
        begin
            bit p0;
            p0 = sag_pulse;
            for (int i = 0; i < 2; i++) cyc(1, -5000, -100, -100, 0);
            pass_chk("R7 B and C set together", 32'h0C00_0000);
            chk("R7 single toggle for two events", {31'd0, sag_pulse}, {31'd0, ~p0});
            sag_irq_en = 1'b0;
            cyc(1, -5000, 5000, 5000, 0);
            for (int i = 0; i < 2; i++) cyc(1, -100, 5000, 5000, 0);
            pass_chk("R7 A set with irq off", 32'h0200_0000);
            chk("R7 no toggle with irq off", {31'd0, sag_pulse}, {31'd0, ~p0});
            cyc(1, -5000, 5000, 5000, 0);
            sag_irq_en = 1'b1;
        end

        // R5: strobe on the setting sample captures old flags
        sag_runlen = 8'd1;
        cyc(1, -100, 5000, 5000, 1);
        cyc(0, 0, 0, 0, 0);
        chk("R5 strobe sees value before edge", status_word, 32'h0);
        idle(3);
        chk("R5 word holds between strobes", status_word, 32'h0);
        pass_chk("R5 next strobe shows A", 32'h0200_0000);
        cyc(1, -5000, 5000, 5000, 0);
        pass_chk("R5 cleared", 32'h0);

        // R6: square wave hysteresis
        sag_level = 16'd10;
        cyc(1, 50, 5000, 5000, 0);
        cyc(1, 64, 5000, 5000, 0);
        pass_chk("R6 inside band stays low", 32'h0);
        cyc(1, 65, 5000, 5000, 0);
        pass_chk("R6 above +64 goes high", 32'h1000_0000);
        cyc(1, -50, 5000, 5000, 0);
        cyc(1, -64, 5000, 5000, 0);
        pass_chk("R6 inside band stays high", 32'h1000_0000);
        cyc(1, -65, 5000, 5000, 0);
        pass_chk("R6 below -64 goes low", 32'h0);

        // R2: run length zero acts as one
        sag_level = 16'd1000; sag_runlen = 8'd0;
        cyc(1, -100, 5000, 5000, 0);
        pass_chk("R2 runlen zero sets at once", 32'h0200_0000);
        cyc(1, -5000, 5000, 5000, 0);

        // mixed waveform run, checked by the model each cycle (R1..R7)
        sag_level = 16'd700; sag_runlen = 8'd3;
        for (int i = 0; i < 400; i++) begin
            int ta, tb, tc, t;
            t = i % 40;
            ta = (t < 20) ? (-2000 + 200 * t) : (2000 - 200 * (t - 20));
            t = (i + 13) % 40;
            tb = (t < 20) ? (-2000 + 200 * t) : (2000 - 200 * (t - 20));
            t = (i + 27) % 40;
            tc = (t < 20) ? (-2000 + 200 * t) : (2000 - 200 * (t - 20));
            if (i == 200) phase_en = 3'b011;
            if (i == 260) phase_en = 3'b111;
            sag_irq_en = (i % 97) < 80;
            cyc((i % 3) != 2, ta, tb, tc, (i % 11) == 0);
        end
        idle(2);

        // R8: reset mid-run clears everything
        sag_level = 16'd1000; sag_runlen = 8'd1; sag_irq_en = 1'b1;
        cyc(1, -5000, -100, 5000, 0);
        pass_chk("R8 B set before reset", 32'h0400_0000);
        @(posedge clk); #1 rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        chk("R8 status after reset", status_word, 32'h0);
        chk("R8 pulse after reset", {31'd0, sag_pulse}, 32'd0);
        pass_chk("R8 flags cleared by reset", 32'h0);

        idle(2);
        finish_run();
    end
endmodule